// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit counter channel. It counts on a clock-enable tick and produces an output waveform that depends on a selected operating mode. A load strobe delivers two things in the same cycle: a count value and a 3-bit mode. The load restarts the channel from that value. A gate input can pause counting or restart it, depending on the mode. The live count is always driven out so a read path can sample it. Counting is binary only. Bus decoding and byte sequencing belong to the surrounding logic.

In what follows, N is the loaded value, with 0 taken as 65536. The elapsed count d is the number of advancing ticks since the last load or restart. The output and the visible count are then fixed functions of the mode, N and d. Six waveforms are offered:
- latch-high at terminal count
- a one-shot that is high until terminal count
- a one-tick rate pulse
- a square wave
- two single-tick strobes

Top module: `interval_timer_ch`

## Requirements
- R1: After reset the channel is in mode 3 with N = 65536 and d = 0. The output is high and the visible count reads 0x0000.
- R2: A loaded value of 0 acts as N = 65536. In mode 0, one tick after such a load the count reads 0xFFFF and the output stays low.
- R3: Mode 0: the output is low while d < N and high from d = N onward, and it stays high. The count reads (N - d) mod 65536 and wraps past zero.
- R4: Mode 1: the output is high while d < N and low afterwards. The count reads (N - d) mod 65536.
- R5: Mode 2: the output is high exactly when d is a nonzero multiple of N, so it is low right after a load. The count reads (N - (d mod N)) mod 65536.
- R6: Mode 3: the output is high while (d mod N) < (N+1)/2 and low for the rest of each period. For an odd N the high phase is one tick longer than the low phase. The count reads (N - (2d mod N)) mod 65536, so it falls by two per tick.
- R7: Modes 4 and 5: the output is high only while d = N, so there is a single one-tick pulse. The count reads (N - d) mod 65536.
- R8: The gate is sampled on ticks. In modes 1, 2, 3 and 5, a tick that sees the gate high after the previous tick saw it low sets d back to 0. In modes 0 and 4 such a tick advances d normally.
- R9: In modes 0, 2, 3 and 4, a tick with the gate low leaves d unchanged. In modes 1 and 5, the gate level does not stop counting.
- R10: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R11: A load takes effect at the clock edge where it is seen, with d = 0 visible in the next cycle. Cycles with no tick and no load change neither the output nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counting-clock enable, one tick per asserted cycle |
| loadStb | input | 1 | Load strobe for loadVal and modeSel |
| modeSel | input | 3 | Operating mode taken at load |
| loadVal | input | 16 | Count value taken at load (0 means 65536) |
| gate | input | 1 | Gate level, sampled on ticks |
| outSig | output | 1 | Channel output waveform |
| countVal | output | 16 | Live visible count |

## Verification
The bench goes after the period edges where an off-by-one shows:
- The mode 2 pulse at the first period boundary. A design that pulsed at the load instant or one tick late would be caught there.
- The mode 3 split for odd and even N. A design that divided the odd period evenly would drop the extra high tick.
- The single strobe in modes 4 and 5. A design that held the pulse or repeated it after the count wraps would be caught.

It also drives gate low and gate rising edges in every mode family. A design that confused pausing with restarting would show a count offset from the expected elapsed-tick value. A zero load is checked so that a design treating 0 as an immediate terminal count would raise the output at once.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef struct packed {
    logic load;     // latch a new period value
    logic restart;  // return to elapsed count zero
    logic advance;  // one elapsed tick
  } itc_strobe_t;
endpackage

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              loadStb,
  input  logic [2:0]        modeSel,
  input  logic              gate,
  output itc_strobe_t       stb,
  output logic [2:0]        curMode
);
  logic gatePrev;
  logic restartKind;
  logic freeRun;
  logic gateEdge;
  logic [2:0] mappedMode;

  // codes 6 and 7 alias onto 2 and 3
  always_comb mappedMode = modeSel[1] ? {1'b0, modeSel[1:0]} : modeSel;

  always_comb begin
    restartKind = curMode inside {3'd1, 3'd2, 3'd3, 3'd5};
    freeRun     = (curMode == 3'd1) || (curMode == 3'd5);
    gateEdge    = tickEn && gate && !gatePrev && restartKind;
    stb.load    = loadStb;
    stb.restart = loadStb || gateEdge;
    stb.advance = !stb.restart && tickEn && (gate || freeRun);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode  <= 3'd3;
      gatePrev <= 1'b0;
    end else begin
      if (loadStb) curMode <= mappedMode;
      if (tickEn) gatePrev <= gate;
    end
  end
endmodule

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  itc_strobe_t       stb,
  input  logic [2:0]        curMode,
  input  logic [CNT_W-1:0]  loadVal,
  output logic              outSig,
  output logic [CNT_W-1:0]  countVal
);
  localparam int PW = CNT_W + 1;
  localparam logic [PW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [PW-1:0]    periodN;
  logic [PW-1:0]    loadN;
  logic [PW-1:0]    nextN;
  logic [PW-1:0]    phase;
  logic [PW-1:0]    dbl;
  logic [PW-1:0]    dblStep;
  logic [PW-1:0]    dblWrap1;
  logic [PW-1:0]    dblWrap2;
  logic [PW-1:0]    halfN;
  logic [CNT_W-1:0] downCnt;
  logic             doneFlag;
  logic             tcFlag;
  logic             started;

  always_comb begin
    loadN    = (loadVal == '0) ? FULL : {1'b0, loadVal};
    nextN    = stb.load ? loadN : periodN;
    dblStep  = dbl + PW'(2);
    dblWrap1 = (dblStep >= periodN) ? dblStep - periodN : dblStep;
    dblWrap2 = (dblWrap1 >= periodN) ? dblWrap1 - periodN : dblWrap1;
    halfN    = (periodN + PW'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodN  <= FULL;
      downCnt  <= FULL[CNT_W-1:0];
      phase    <= '0;
      dbl      <= '0;
      doneFlag <= 1'b0;
      tcFlag   <= 1'b0;
      started  <= 1'b0;
    end else if (stb.restart) begin
      periodN  <= nextN;
      downCnt  <= nextN[CNT_W-1:0];
      phase    <= '0;
      dbl      <= '0;
      doneFlag <= 1'b0;
      tcFlag   <= 1'b0;
      started  <= 1'b0;
    end else if (stb.advance) begin
      downCnt  <= downCnt - CNT_W'(1);
      tcFlag   <= (downCnt == CNT_W'(1)) && !doneFlag;
      if (downCnt == CNT_W'(1)) doneFlag <= 1'b1;
      phase    <= (phase == periodN - PW'(1)) ? '0 : phase + PW'(1);
      dbl      <= dblWrap2;
      started  <= 1'b1;
    end
  end

  always_comb begin
    case (curMode)
      3'd0:    outSig = doneFlag;
      3'd1:    outSig = !doneFlag;
      3'd2:    outSig = started && (phase == '0);
      3'd3:    outSig = (phase < halfN);
      default: outSig = tcFlag;
    endcase
    case (curMode)
      3'd2:    countVal = periodN[CNT_W-1:0] - phase[CNT_W-1:0];
      3'd3:    countVal = periodN[CNT_W-1:0] - dbl[CNT_W-1:0];
      default: countVal = downCnt;
    endcase
  end
endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             loadStb,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             gate,
  output logic             outSig,
  output logic [CNT_W-1:0] countVal
);
  itc_strobe_t stb;
  logic [2:0]  curMode;

  itc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .loadStb (loadStb),
    .modeSel (modeSel),
    .gate    (gate),
    .stb     (stb),
    .curMode (curMode)
  );

  itc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .curMode  (curMode),
    .loadVal  (loadVal),
    .outSig   (outSig),
    .countVal (countVal)
  );
endmodule

// File: rtl/itc_chk.sv
module itc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             loadStb,
  input logic [2:0]       modeSel,
  input logic             gate,
  input logic             outSig,
  input logic [CNT_W-1:0] countVal,
  input logic [2:0]       curMode
);
  // R3: once high in mode 0, the output stays high until a new load
  a_r3_sticky_high: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd0) && outSig && !loadStb |=> outSig);

  // R7: a strobe lasts a single advancing tick
  a_r7_one_tick: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode == 3'd4) || (curMode == 3'd5)) && outSig && tickEn && gate && !loadStb
    |=> !outSig);

  // R5: no rate pulse at the load instant
  a_r5_low_after_load: assert property (@(posedge clk) disable iff (!rstN)
    loadStb && ((modeSel == 3'd2) || (modeSel == 3'd6)) |=> !outSig);

  // R9: gate low freezes mode 0
  a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd0) && tickEn && !gate && !loadStb
    |=> $stable(countVal) && $stable(outSig));

  // R11: nothing moves without a tick or a load
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !loadStb |=> $stable(countVal) && $stable(outSig));
endmodule

bind interval_timer_ch itc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .loadStb  (loadStb),
  .modeSel  (modeSel),
  .gate     (gate),
  .outSig   (outSig),
  .countVal (countVal),
  .curMode  (curMode)
);

// File: tb/sim_interval_timer_ch.sv
module sim_interval_timer_ch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        loadStb = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic [15:0] loadVal = 16'd0;
  logic        gate = 1'b0;
  logic        outSig;
  logic [15:0] countVal;

  int nChk = 0;
  int nBad = 0;
  int mN, mMode, mD;
  bit mPrev;
  bit finished = 1'b0;

  // {mode, value, ticks}
  localparam logic [26:0] VEC [0:10] = '{
    {3'd0, 16'd5, 8'd8},
    {3'd1, 16'd3, 8'd5},
    {3'd2, 16'd4, 8'd10},
    {3'd3, 16'd5, 8'd12},
    {3'd3, 16'd6, 8'd8},
    {3'd4, 16'd3, 8'd6},
    {3'd5, 16'd2, 8'd5},
    {3'd6, 16'd3, 8'd7},
    {3'd7, 16'd3, 8'd7},
    {3'd2, 16'd1, 8'd3},
    {3'd0, 16'd0, 8'd3}
  };

  interval_timer_ch u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .loadStb(loadStb),
    .modeSel(modeSel), .loadVal(loadVal), .gate(gate),
    .outSig(outSig), .countVal(countVal)
  );

  always #2 clk = ~clk;

  function automatic bit expOut();
    case (mMode)
      0: return mD >= mN;
      1: return mD < mN;
      2: return ((mD % mN) == 0) && (mD != 0);
      3: return (mD % mN) < ((mN + 1) / 2);
      default: return mD == mN;
    endcase
  endfunction

  function automatic int expCnt();
    int r;
    case (mMode)
      2: r = mN - (mD % mN);
      3: r = mN - ((2 * mD) % mN);
      default: r = mN - mD;
    endcase
    return r & 16'hFFFF;
  endfunction

  task automatic check(string tag);
    bit eo;
    int ec;
    eo = expOut();
    ec = expCnt();
    nChk++;
    if (outSig !== eo) begin
      nBad++;
      $display("FAIL %s out act=%0d exp=%0d (mode %0d N %0d d %0d)", tag, outSig, eo, mMode, mN, mD);
    end
    nChk++;
    if (countVal !== ec[15:0]) begin
      nBad++;
      $display("FAIL %s count act=%0d exp=%0d (mode %0d N %0d d %0d)", tag, countVal, ec, mMode, mN, mD);
    end
  endtask

  task automatic doTick(bit g, string tag);
    bit rk;
    @(negedge clk);
    tickEn = 1'b1;
    gate = g;
    @(posedge clk);
    rk = (mMode == 1) || (mMode == 2) || (mMode == 3) || (mMode == 5);
    if (g && !mPrev && rk) mD = 0;
    else if (g || mMode == 1 || mMode == 5) mD++;
    mPrev = g;
    @(negedge clk);
    tickEn = 1'b0;
    check(tag);
  endtask

  task automatic doLoad(int m, int v, string tag);
    @(negedge clk);
    loadStb = 1'b1;
    modeSel = m[2:0];
    loadVal = v[15:0];
    @(negedge clk);
    loadStb = 1'b0;
    mMode = (m >= 6) ? m - 4 : m;
    mN = (v == 0) ? 65536 : v;
    mD = 0;
    check(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tickEn = 1'b0;
    loadStb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mMode = 3;
    mN = 65536;
    mD = 0;
    mPrev = 1'b0;
    @(negedge clk);
    check("R1");
  endtask

  function automatic string tagFor(int m, int v);
    if (v == 0) return "R2";
    if (m >= 6) return "R10";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    doReset();
    doTick(1'b1, "R1");
    doTick(1'b1, "R1");
    doTick(1'b1, "R1");

    for (int i = 0; i < 11; i++) begin
      int m, v, n;
      m = int'(VEC[i][26:24]);
      v = int'(VEC[i][23:8]);
      n = int'(VEC[i][7:0]);
      doLoad(m, v, "R11");
      for (int k = 0; k < n; k++) doTick(1'b1, tagFor(m, v));
    end

    // R9 mode 0 pause, rising gate does not restart (R8)
    doLoad(0, 4, "R11");
    doTick(1'b1, "R9");
    doTick(1'b0, "R9");
    doTick(1'b0, "R9");
    doTick(1'b1, "R8");
    doTick(1'b1, "R3");
    doTick(1'b1, "R3");

    // R8 mode 2 pause then restart on rising gate
    doLoad(2, 5, "R5");
    doTick(1'b1, "R5");
    doTick(1'b1, "R5");
    doTick(1'b0, "R9");
    doTick(1'b1, "R8");
    doTick(1'b1, "R8");

    // mode 5: gate low keeps counting, rising edge restarts
    doLoad(5, 4, "R7");
    doTick(1'b0, "R9");
    doTick(1'b0, "R9");
    doTick(1'b1, "R8");
    for (int k = 0; k < 5; k++) doTick(1'b1, "R7");

    // mode 4: gate low holds, rising edge just advances
    doLoad(4, 3, "R7");
    doTick(1'b0, "R9");
    doTick(1'b1, "R8");
    for (int k = 0; k < 3; k++) doTick(1'b1, "R7");

    // mode 1 retrigger
    doLoad(1, 2, "R4");
    doTick(1'b1, "R4");
    doTick(1'b1, "R4");
    doTick(1'b0, "R9");
    doTick(1'b1, "R8");

    // idle cycles leave state alone
    doLoad(0, 9, "R11");
    repeat (3) @(negedge clk);
    check("R11");

    // reset mid-run
    doReset();

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule